// File: doc/BRIEF.md
# Pseudo-Random Fault Injection Engine

This block corrupts a data word on its way through a datapath so that the surrounding logic can be tested against soft errors. A shift register with linear feedback picks the bit position for each fault. Its feedback taps and its start value are both loaded through a configuration port. A criticality mask marks the bits that may be hit. Every fault pattern is ANDed with the mask, so a bit outside the mask is never flipped.

Four fault models are selected by a 2-bit code. The single-bit model flips one bit. The cluster model flips a group of 2 to 8 neighbouring bits, and the group wraps around the top of the word. The burst model flips one freshly drawn bit on each cycle of a run of consecutive cycles. The fourth code is reserved and does nothing. The corrupted word, the applied XOR pattern and a flag all appear combinationally in the cycle in which the fault is applied.

Top module: `lfsr_fault_engine`

## Requirements
- R1: After reset the generator state is 16'hACE1, the feedback taps are 16'hB400 and no burst is pending.
- R2: The generator is a left-shifting register. The new bit 0 is the XOR of all state bits selected by the taps. It advances by one step at each clock edge where a non-zero pattern is applied and no load occurs, and otherwise it holds. A next value of zero is replaced by 16'h0001.
- R3: A configuration load takes the taps and the seed at the clock edge and has priority over a step. A seed of zero is stored as 16'h0001.
- R4: The fault anchor is found by scanning upward from position (state mod W), wrapping at the top of the word. It is the first bit whose mask bit is 1.
- R5: Code 00 (single upset) with enable and inject high flips exactly the anchor bit. This happens whenever the mask is not all zeros.
- R6: Code 01 (cluster upset) flips N adjacent bits from the anchor upward, wrapping modulo W, and keeps only the bits in the mask. N is cluster_width+1, with the values 0 and 1 both giving N=2 and the value 7 giving N=8.
- R7: Code 10 (burst) flips the anchor bit in the inject cycle. On each of the next burst_cycles-1 cycles it flips one newly drawn anchor bit, and a burst_cycles value of 0 or 1 gives a single cycle. While a burst runs, inject and the mode code are ignored. A burst starts only if the first cycle applied a fault.
- R8: Code 11 is reserved and applies no fault.
- R9: A bit whose mask bit is 0 is never flipped. An all-zero mask applies nothing, keeps the flag low and leaves the generator unchanged.
- R10: With enable low, inject is ignored. Dropping enable also cancels any burst in progress from the next cycle onward.
- R11: In the same cycle, data_out equals data_in XOR xor_pattern, and fault_applied is high exactly when xor_pattern is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load taps and seed at this edge |
| cfg_poly | input | LW | Feedback tap vector |
| cfg_seed | input | LW | Start value, zero is replaced |
| enable | input | 1 | Master enable for injection |
| inject | input | 1 | Injection strobe |
| fault_mode | input | 2 | 00 single, 01 cluster, 10 burst, 11 reserved |
| crit_mask | input | W | 1 marks a bit that may be corrupted |
| cluster_width | input | 3 | Cluster size code |
| burst_cycles | input | BLW | Burst length in cycles |
| data_in | input | W | Clean data word |
| data_out | output | W | Corrupted data word |
| fault_applied | output | 1 | High when any bit is flipped this cycle |
| xor_pattern | output | W | Pattern XORed onto the word |

## Verification
A wrong generator state shows up at the first later injection, because the flipped bit lands at a position other than (state mod W) adjusted by the mask. After a missed or extra step, every later position is shifted as well. A wrong burst counter shows within the burst length: flips arrive in cycles after the burst should have ended, or they are missing in cycles inside it. A wrong anchor scan or mask gate shows in the same cycle, as a flip on a masked bit or as a pattern with the wrong bit count.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    FM_SINGLE  = 2'b00,
    FM_CLUSTER = 2'b01,
    FM_BURST   = 2'b10,
    FM_RSVD    = 2'b11
  } fault_mode_e;

  localparam int MAX_CLUSTER = 8;
endpackage

// File: rtl/fi_lfsr.sv
module fi_lfsr #(
  parameter int            LW       = 16,
  parameter logic [LW-1:0] POLY_RST = 16'hB400,
  parameter logic [LW-1:0] SEED_RST = 16'hACE1,
  parameter logic [LW-1:0] NZ_FILL  = 16'h0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] poly_in,
  input  logic [LW-1:0] seed_in,
  input  logic          step,
  output logic [LW-1:0] state
);
  logic [LW-1:0] poly_q;

  // one Fibonacci step, zero result is forced to a live value
  function automatic logic [LW-1:0] lfsr_next(input logic [LW-1:0] s, input logic [LW-1:0] p);
    logic [LW-1:0] n;
    n = {s[LW-2:0], ^(s & p)};
    return (n == '0) ? NZ_FILL : n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEED_RST;
      poly_q <= POLY_RST;
    end else if (load) begin
      poly_q <= poly_in;
      state  <= (seed_in == '0) ? NZ_FILL : seed_in;
    end else if (step) begin
      state <= lfsr_next(state, poly_q);
    end
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  assert_zero_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed_in == '0) |=> state == NZ_FILL);
endmodule

// File: rtl/fi_burst_ctl.sv
module fi_burst_ctl #(
  parameter int BLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           start,
  input  logic [BLW-1:0] len,
  output logic           busy,
  output logic [BLW-1:0] remain
);
  always_ff @(posedge clk) begin
    if (!rst_n)               remain <= '0;
    else if (!enable)         remain <= '0;
    else if (busy)            remain <= remain - 1'b1;
    else if (start && len > 1) remain <= len - 1'b1;
  end

  assign busy = (remain != '0);

  assert_burst_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enable) |=> remain == $past(remain) - 1'b1);
  assert_burst_cancel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
endmodule

// File: rtl/fi_pattern.sv
module fi_pattern
  import fi_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 16
) (
  input  logic [LW-1:0]  state,
  input  logic [W-1:0]   mask,
  input  fault_mode_e    mode,
  input  logic [2:0]     cluster_width,
  input  logic           burst_active,
  input  logic           trig,
  output logic [W-1:0]   pat
);
  localparam int PW = $clog2(W);

  logic [PW-1:0] anchor;
  logic [W-1:0]  one_hot;
  logic [W-1:0]  raw;

  // first critical bit at or above state mod W, wrapping
  function automatic logic [PW-1:0] anchor_of(input logic [LW-1:0] s, input logic [W-1:0] m);
    int base;
    int idx;
    logic [PW-1:0] a;
    logic found;
    base  = int'(32'(s) % W);
    a     = PW'(base);
    found = 1'b0;
    for (int k = 0; k < W; k++) begin
      idx = (base + k) % W;
      if (!found && m[idx]) begin
        a     = PW'(idx);
        found = 1'b1;
      end
    end
    return a;
  endfunction

  // N adjacent bits from the anchor, wrapping
  function automatic logic [W-1:0] cluster_of(input logic [PW-1:0] a, input logic [2:0] cw);
    logic [W-1:0] r;
    int n;
    r = '0;
    n = (cw < 3'd2) ? 2 : int'(cw) + 1;
    for (int k = 0; k < MAX_CLUSTER; k++) begin
      if (k < n) r[(int'(a) + k) % W] = 1'b1;
    end
    return r;
  endfunction

  assign anchor = anchor_of(state, mask);

  always_comb begin
    one_hot         = '0;
    one_hot[anchor] = 1'b1;
    raw             = '0;
    if (burst_active) begin
      raw = one_hot;
    end else if (trig) begin
      case (mode)
        FM_SINGLE, FM_BURST: raw = one_hot;
        FM_CLUSTER:          raw = cluster_of(anchor, cluster_width);
        default:             raw = '0;
      endcase
    end
    pat = raw & mask;
  end
endmodule

// File: rtl/lfsr_fault_engine.sv
module lfsr_fault_engine
  import fi_pkg::*;
#(
  parameter int W   = 16,
  parameter int LW  = 16,
  parameter int BLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [LW-1:0]  cfg_poly,
  input  logic [LW-1:0]  cfg_seed,
  input  logic           enable,
  input  logic           inject,
  input  logic [1:0]     fault_mode,
  input  logic [W-1:0]   crit_mask,
  input  logic [2:0]     cluster_width,
  input  logic [BLW-1:0] burst_cycles,
  input  logic [W-1:0]   data_in,
  output logic [W-1:0]   data_out,
  output logic           fault_applied,
  output logic [W-1:0]   xor_pattern
);
  logic [LW-1:0]  lfsr_state;
  logic           burst_busy;
  logic [BLW-1:0] burst_left;
  logic           trig;
  logic           burst_start;
  fault_mode_e    mode_e;

  assign mode_e      = fault_mode_e'(fault_mode);
  assign trig        = enable && inject && !burst_busy;
  assign burst_start = trig && (mode_e == FM_BURST) && fault_applied;

  fi_lfsr #(.LW(LW)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .poly_in(cfg_poly),
    .seed_in(cfg_seed), .step(fault_applied), .state(lfsr_state)
  );

  fi_burst_ctl #(.BLW(BLW)) u_burst (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(burst_start),
    .len(burst_cycles), .busy(burst_busy), .remain(burst_left)
  );

  fi_pattern #(.W(W), .LW(LW)) u_pat (
    .state(lfsr_state), .mask(crit_mask), .mode(mode_e),
    .cluster_width(cluster_width), .burst_active(burst_busy && enable),
    .trig(trig), .pat(xor_pattern)
  );

  assign fault_applied = |xor_pattern;
  assign data_out      = data_in ^ xor_pattern;

  assert_masked_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xor_pattern & ~crit_mask) == '0);
  assert_single_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_e == FM_SINGLE && |crit_mask) |-> $countones(xor_pattern) == 1);
  assert_cluster_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_e == FM_CLUSTER && |crit_mask) |->
      ($countones(xor_pattern) >= 1 && $countones(xor_pattern) <= MAX_CLUSTER));
  assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && mode_e == FM_RSVD) |-> xor_pattern == '0);
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> xor_pattern == '0);
  assert_lfsr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_applied && !cfg_load) |=> $stable(lfsr_state));
endmodule

// File: tb/test_lfsr_fault_engine.sv
module test_lfsr_fault_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [15:0] cfg_poly = '0;
  logic [15:0] cfg_seed = '0;
  logic        enable = 1'b0;
  logic        inject = 1'b0;
  logic [1:0]  fault_mode = '0;
  logic [15:0] crit_mask = '0;
  logic [2:0]  cluster_width = '0;
  logic [7:0]  burst_cycles = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        fault_applied;
  logic [15:0] xor_pattern;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_state, m_poly;
  int          m_cnt;

  always #10 clk = ~clk;

  lfsr_fault_engine i_lfsr_fault_engine (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_poly(cfg_poly),
    .cfg_seed(cfg_seed), .enable(enable), .inject(inject), .fault_mode(fault_mode),
    .crit_mask(crit_mask), .cluster_width(cluster_width), .burst_cycles(burst_cycles),
    .data_in(data_in), .data_out(data_out), .fault_applied(fault_applied),
    .xor_pattern(xor_pattern)
  );

  function automatic logic [15:0] m_next(logic [15:0] s, logic [15:0] p);
    bit fb = 1'b0;
    logic [15:0] n;
    for (int i = 0; i < 16; i++) if (p[i]) fb = fb ^ s[i];
    n = {s[14:0], fb};
    if (n == 16'h0) n = 16'h0001;
    return n;
  endfunction

  function automatic int m_anchor(logic [15:0] s, logic [15:0] mk);
    int p = int'(s) % 16;
    for (int k = 0; k < 16; k++) if (mk[(p + k) % 16]) return (p + k) % 16;
    return p;
  endfunction

  function automatic logic [15:0] m_cluster(int a, logic [2:0] cw);
    logic [15:0] r = '0;
    int n = (int'(cw) <= 1) ? 2 : int'(cw) + 1;
    for (int k = 0; k < n; k++) r[(a + k) % 16] = 1'b1;
    return r;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit ld, input logic [15:0] pl, input logic [15:0] sd,
                      input bit en, input bit inj, input logic [1:0] md,
                      input logic [15:0] mk, input logic [2:0] cw, input logic [7:0] bl,
                      input string tag_in);
    logic [15:0] exp;
    logic [15:0] oh;
    bit busy;
    string tag;
    @(negedge clk);
    cfg_load = ld; cfg_poly = pl; cfg_seed = sd; enable = en; inject = inj;
    fault_mode = md; crit_mask = mk; cluster_width = cw; burst_cycles = bl;
    data_in = 16'($urandom);
    #1;
    busy = (m_cnt != 0);
    oh = 16'h1 << m_anchor(m_state, mk);
    exp = '0;
    if (!en) tag = "R10";
    else if (busy) tag = "R7";
    else if (!inj) tag = "R4";
    else if (mk == 16'h0) tag = "R9";
    else if (md == 2'b00) tag = "R5";
    else if (md == 2'b01) tag = "R6";
    else if (md == 2'b10) tag = "R7";
    else tag = "R8";
    if (tag_in != "") tag = tag_in;
    if (en && busy) exp = oh;
    else if (en && inj) begin
      if (md == 2'b00 || md == 2'b10) exp = oh;
      else if (md == 2'b01) exp = m_cluster(m_anchor(m_state, mk), cw);
    end
    exp = exp & mk;
    chk(xor_pattern, exp, tag, "xor_pattern");
    chk(data_out, data_in ^ exp, "R11", "data_out");
    chk(16'(fault_applied), 16'(exp != 0), "R11", "fault_applied");
    chk(xor_pattern & ~mk, 16'h0, "R9", "masked bits");
    // model update for the coming edge
    if (!en) m_cnt = 0;
    else if (busy) m_cnt = m_cnt - 1;
    else if (inj && md == 2'b10 && exp != 0 && bl > 1) m_cnt = int'(bl) - 1;
    if (ld) begin
      m_poly = pl;
      m_state = (sd == 16'h0) ? 16'h0001 : sd;
    end else if (exp != 0) m_state = m_next(m_state, m_poly);
  endtask

  task automatic inj1(input logic [1:0] md, input logic [15:0] mk, input logic [2:0] cw,
                      input logic [7:0] bl, input string tag);
    step(1'b0, 16'h0, 16'h0, 1'b1, 1'b1, md, mk, cw, bl, tag);
  endtask

  task automatic idle(input logic [15:0] mk, input string tag);
    step(1'b0, 16'h0, 16'h0, 1'b1, 1'b0, 2'b00, mk, 3'd0, 8'd0, tag);
  endtask

  task automatic load(input logic [15:0] pl, input logic [15:0] sd);
    step(1'b1, pl, sd, 1'b0, 1'b0, 2'b00, 16'hFFFF, 3'd0, 8'd0, "R3");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_state = 16'hACE1; m_poly = 16'hB400; m_cnt = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    data_in = 16'h5A5A;
    #1;
    chk(data_out, 16'h5A5A, "R1", "data_out in reset");
    chk(xor_pattern, 16'h0, "R1", "xor in reset");
    rst_n = 1'b1;
    // R1: reset state ACE1 -> position 1
    inj1(2'b00, 16'hFFFF, 3'd0, 8'd0, "R1");
    // R3: zero seed becomes 1
    load(16'hB400, 16'h0000);
    inj1(2'b00, 16'hFFFF, 3'd0, 8'd0, "R3");
    load(16'hB400, 16'h0005);
    inj1(2'b00, 16'hFFFF, 3'd0, 8'd0, "R3");
    inj1(2'b00, 16'hFFFF, 3'd0, 8'd0, "R2");
    // R9: empty mask applies nothing, R2: state held afterwards
    inj1(2'b00, 16'h0000, 3'd0, 8'd0, "R9");
    inj1(2'b00, 16'hFFFF, 3'd0, 8'd0, "R2");
    // R4: sparse mask scan with wrap
    load(16'hB400, 16'h0005);
    inj1(2'b00, 16'h0010, 3'd0, 8'd0, "R4");
    load(16'hB400, 16'h000E);
    inj1(2'b00, 16'h8000, 3'd0, 8'd0, "R4");
    // R6: cluster wrapping, size codes 7 and 0
    load(16'hB400, 16'h000E);
    inj1(2'b01, 16'hFFFF, 3'd7, 8'd0, "R6");
    load(16'hB400, 16'h000F);
    inj1(2'b01, 16'hFFFF, 3'd0, 8'd0, "R6");
    inj1(2'b01, 16'h0F0F, 3'd5, 8'd0, "R6");
    // R8: reserved code
    inj1(2'b11, 16'hFFFF, 3'd3, 8'd4, "R8");
    // R10: enable low ignores inject
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b1, 2'b00, 16'hFFFF, 3'd0, 8'd0, "R10");
    // R7: burst of 4 with inject and mode changed mid-burst
    inj1(2'b10, 16'hFFFF, 3'd0, 8'd4, "R7");
    inj1(2'b11, 16'hFFFF, 3'd0, 8'd4, "R7");
    idle(16'hFFFF, "R7");
    idle(16'hFFFF, "R7");
    idle(16'hFFFF, "R7");
    // R7: burst length 0 is one cycle
    inj1(2'b10, 16'hFFFF, 3'd0, 8'd0, "R7");
    idle(16'hFFFF, "R7");
    // R10: enable drop cancels burst
    inj1(2'b10, 16'hFFFF, 3'd0, 8'd9, "R7");
    idle(16'hFFFF, "R7");
    step(1'b0, 16'h0, 16'h0, 1'b0, 1'b0, 2'b00, 16'hFFFF, 3'd0, 8'd0, "R10");
    idle(16'hFFFF, "R10");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] mk;
      logic [15:0] sd;
      mk = ($urandom % 8 == 0) ? 16'h0 : 16'($urandom);
      sd = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      step(($urandom % 40) == 0, 16'($urandom) | 16'h8000, sd,
           ($urandom % 10) != 0, ($urandom % 2) == 0, 2'($urandom),
           mk, 3'($urandom), 8'($urandom % 7), "");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule